// File: doc/BRIEF.md
# Serial Stimulation Frame Controller

This block sits behind a one-wire serial receiver and turns a continuous bit stream into the control strobes that drive a row-scanned stimulator array. One bit arrives on every rising clock edge, most significant bit first. The bits enter a 40-bit shift register. While the block is idle it watches the newest 16 bits for a start tag. After the start tag it takes the next 40-bit word as a pulse-timing configuration and keeps its low 18 bits. It then receives five 40-bit row words, one after another, with no gaps between them. Each row word holds five 8-bit amplitude bytes, one per probe.

After the fifth row comes a sync word. If the low 16 bits of the sync word equal 0xAAAA, the block goes straight on to the next frame. Later frames therefore send only rows and a sync word, and the start tag and configuration word are not repeated. If the sync word is wrong, the block falls back to searching for a start tag. All strobes are Moore outputs decoded from a seven-state machine. A free-running 40-bit word counter and a row counter pace that machine.

Top module: `stim_frame_ctrl`

## Requirements
- R1: While reset is low, and in the first cycle after it is released, every strobe and level output is low, `row_num` is 0, `cfg_word` is 0 and `probe_lvl` is 0.
- R2: When the newest 16 received bits equal 0xEEEE in the idle state, the next 40 bits form the configuration word. `cfg_stb` is high for exactly the cycle after the 40th of those bits. From the following cycle on, `cfg_word` equals the low 18 bits of that word and keeps that value until the next configuration word is captured.
- R3: `dreg_run` is low while idle and while the configuration word shifts in. It goes high in the `cfg_stb` cycle and stays high until the block returns to idle.
- R4: For each row word, `row_latch` and `row_clk` are high for exactly the one cycle after its 40th bit. `probe_lvl` takes the new row in the next cycle and holds its value at all other times.
- R5: `probe_lvl[8k+7:8k]` holds the (k+1)-th byte received in the row word, for k = 0..4. The first byte on the wire (row word bits 39:32) is probe 1, and the last byte (bits 7:0) is probe 5.
- R6: `tmr_run` is high while a row word or the sync word shifts in, and low in the latch cycle. `scan_run` is high throughout the row phase, including the latch, sync-check and restart cycles. Both are low while idle and during configuration.
- R7: `row_num` shows 1 to 5 during the matching latch cycle. The sixth word of a frame is never latched: in the cycle after its 40th bit, `row_latch` is low and `row_num` is 6.
- R8: If the low 16 bits of the sixth word equal 0xAAAA, one restart cycle follows with `scan_run` high and `tmr_run` low. Both counters restart, and the next word is row 1 of a new frame, with no start tag or configuration word in between. `cfg_word` is kept.
- R9: If the sixth word does not match, the block returns to idle one cycle after the sync check, with all strobe and level outputs low, and it needs a new start tag.
- R10: While idle, bits that do not complete the start tag leave every output unchanged.
- R11: In any cycle, at most one of `cfg_stb`, `row_latch` and `tmr_run` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; one serial bit is sampled on each rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sdi | input | 1 | Serial data, MSB of each word first |
| dreg_run | output | 1 | High releases the downstream data register from clear |
| cfg_stb | output | 1 | One-cycle strobe: configuration word is being captured |
| tmr_run | output | 1 | Pulse-timer run level; its low cycles reload the timer |
| row_latch | output | 1 | One-cycle strobe: the completed row word is being latched |
| scan_run | output | 1 | Row-scan enable for the probe-row decoder |
| row_clk | output | 1 | Advance pulse for the probe-row decoder |
| row_num | output | 3 | Count of words received in the current frame (1..6) |
| cfg_word | output | 18 | Captured pulse-timing configuration |
| probe_lvl | output | 40 | Latched row amplitudes, probe 1 in the low byte |

## Verification
The assertions assume that `sdi` carries an unbroken stream of exactly one bit per clock, so every word boundary falls on a count of 40 with no idle gap, and that reset is the only way the stream is broken. The bench keeps to this rule by driving a new bit on every falling edge and never pausing. The noise it sends while the block is idle is random, except that any bit that would complete 0xEEEE in the last 16 bits is flipped. The leading filler before a start tag is all ones, so the tag cannot be found early by overlapping with earlier bits. Sync words are chosen to be either exactly 0xAAAA in their low 16 bits or forced to a different value.

// File: rtl/sfc_pkg.sv
package sfc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CFG_SHIFT,
        ST_CFG_LATCH,
        ST_ROW_SHIFT,
        ST_ROW_LATCH,
        ST_SYNC_CHK,
        ST_RESTART
    } sfc_state_e;

endpackage

// File: rtl/sfc_shreg.sv
module sfc_shreg #(
    parameter int                WORD_W    = 40,
    parameter int                TAG_W     = 16,
    parameter logic [TAG_W-1:0]  START_TAG = 16'hEEEE,
    parameter logic [TAG_W-1:0]  SYNC_TAG  = 16'hAAAA
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sdi,
    output logic [WORD_W-1:0] word,
    output logic              start_hit,
    output logic              sync_hit
);

    logic [WORD_W-1:0] word_d, word_q;

    // newest bit enters at the LSB, so the first bit of a word ends at the MSB
    always_comb begin
        word_d = {word_q[WORD_W-2:0], sdi};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) word_q <= '0;
        else        word_q <= word_d;
    end

    assign word      = word_q;
    assign start_hit = (word_q[TAG_W-1:0] == START_TAG);
    assign sync_hit  = (word_q[TAG_W-1:0] == SYNC_TAG);

    // R4: every edge moves the old contents up by one place
    p_shift_r4: assert property (@(posedge clk) disable iff (!rst_n)
        word_q[WORD_W-1:1] == $past(word_q[WORD_W-2:0]));

endmodule

// File: rtl/sfc_bitcnt.sv
module sfc_bitcnt #(
    parameter int WORD_W = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic seed,
    output logic tick
);

    localparam int CNT_W = $clog2(WORD_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (seed)
            cnt_d = CNT_W'(1);
        else if (!en)
            cnt_d = '0;
        else if (cnt_q == LAST)
            cnt_d = '0;
        else
            cnt_d = cnt_q + CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign tick = en && (cnt_q == LAST);

    p_cnt_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);

    p_seed_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
        seed |=> (cnt_q == CNT_W'(1)));

endmodule

// File: rtl/sfc_rowcnt.sv
module sfc_rowcnt #(
    parameter int NROWS = 5
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           inc,
    input  logic                           clr,
    output logic [$clog2(NROWS+2)-1:0]     num,
    output logic                           last
);

    localparam int ROW_W = $clog2(NROWS + 2);

    logic [ROW_W-1:0] num_d, num_q;

    always_comb begin
        if (clr)
            num_d = '0;
        else if (inc)
            num_d = num_q + ROW_W'(1);
        else
            num_d = num_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) num_q <= '0;
        else        num_q <= num_d;
    end

    assign num  = num_q;
    assign last = (num_q == ROW_W'(NROWS));

    p_row_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        num_q <= ROW_W'(NROWS + 1));

    p_row_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !clr) |=> (num_q == $past(num_q) + ROW_W'(1)));

endmodule

// File: rtl/stim_frame_ctrl.sv
module stim_frame_ctrl
    import sfc_pkg::*;
#(
    parameter int               WORD_W    = 40,
    parameter int               PIX_W     = 8,
    parameter int               NROWS     = 5,
    parameter int               CFG_W     = 18,
    parameter int               TAG_W     = 16,
    parameter logic [TAG_W-1:0] START_TAG = 16'hEEEE,
    parameter logic [TAG_W-1:0] SYNC_TAG  = 16'hAAAA
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         sdi,
    output logic                         dreg_run,
    output logic                         cfg_stb,
    output logic                         tmr_run,
    output logic                         row_latch,
    output logic                         scan_run,
    output logic                         row_clk,
    output logic [$clog2(NROWS+2)-1:0]   row_num,
    output logic [CFG_W-1:0]             cfg_word,
    output logic [WORD_W-1:0]            probe_lvl
);

    localparam int ROW_W  = $clog2(NROWS + 2);
    localparam int NPROBE = WORD_W / PIX_W;

    typedef struct packed {
        sfc_state_e        st;
        logic [CFG_W-1:0]  cfg;
        logic [WORD_W-1:0] row;
    } regs_t;

    regs_t             d, q;
    logic [WORD_W-1:0] word;
    logic              start_hit, sync_hit;
    logic              tick;
    logic              row_inc, row_clr, row_last;
    logic              cnt_en, cnt_seed;
    logic [ROW_W-1:0]  row_cnt;

    sfc_shreg #(
        .WORD_W    (WORD_W),
        .TAG_W     (TAG_W),
        .START_TAG (START_TAG),
        .SYNC_TAG  (SYNC_TAG)
    ) u_shreg (
        .clk       (clk),
        .rst_n     (rst_n),
        .sdi       (sdi),
        .word      (word),
        .start_hit (start_hit),
        .sync_hit  (sync_hit)
    );

    sfc_bitcnt #(
        .WORD_W (WORD_W)
    ) u_bitcnt (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (cnt_en),
        .seed  (cnt_seed),
        .tick  (tick)
    );

    sfc_rowcnt #(
        .NROWS (NROWS)
    ) u_rowcnt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (row_inc),
        .clr   (row_clr),
        .num   (row_cnt),
        .last  (row_last)
    );

    assign cnt_en   = (q.st != ST_IDLE);
    assign cnt_seed = (q.st == ST_IDLE) && start_hit;
    assign row_inc  = (q.st == ST_ROW_SHIFT) && tick;
    assign row_clr  = (q.st == ST_IDLE) || (q.st == ST_RESTART);

    always_comb begin
        d = q;
        case (q.st)
            ST_IDLE: begin
                if (start_hit) d.st = ST_CFG_SHIFT;
            end
            ST_CFG_SHIFT: begin
                if (tick) d.st = ST_CFG_LATCH;
            end
            ST_CFG_LATCH: begin
                d.cfg = word[CFG_W-1:0];
                d.st  = ST_ROW_SHIFT;
            end
            ST_ROW_SHIFT: begin
                if (tick) d.st = row_last ? ST_SYNC_CHK : ST_ROW_LATCH;
            end
            ST_ROW_LATCH: begin
                d.row = word;
                d.st  = ST_ROW_SHIFT;
            end
            ST_SYNC_CHK: begin
                d.st = sync_hit ? ST_RESTART : ST_IDLE;
            end
            ST_RESTART: begin
                d.st = ST_ROW_SHIFT;
            end
            default: begin
                d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: ST_IDLE, cfg: '0, row: '0};
        else        q <= d;
    end

    assign dreg_run  = (q.st != ST_IDLE) && (q.st != ST_CFG_SHIFT);
    assign cfg_stb   = (q.st == ST_CFG_LATCH);
    assign tmr_run   = (q.st == ST_ROW_SHIFT);
    assign row_latch = (q.st == ST_ROW_LATCH);
    assign row_clk   = (q.st == ST_ROW_LATCH);
    assign scan_run  = (q.st == ST_ROW_SHIFT) || (q.st == ST_ROW_LATCH) ||
                       (q.st == ST_SYNC_CHK)  || (q.st == ST_RESTART);
    assign row_num   = row_cnt;
    assign cfg_word  = q.cfg;

    // first byte on the wire (word MSBs) lands in the lowest probe slot
    for (genvar k = 0; k < NPROBE; k++) begin : g_probe
        assign probe_lvl[k*PIX_W +: PIX_W] = q.row[WORD_W-1-k*PIX_W -: PIX_W];
    end

    p_cfg_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(cfg_stb) |-> $stable(cfg_word));

    p_probe_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(row_latch) |-> $stable(probe_lvl));

    p_latch_on_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
        row_latch |-> $past(tick));

    p_rownum_r7: assert property (@(posedge clk) disable iff (!rst_n)
        row_latch |-> (row_num >= ROW_W'(1) && row_num <= ROW_W'(NROWS)));

    p_sync_fail_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_SYNC_CHK && !sync_hit) |=> (!dreg_run && !scan_run));

    p_sync_ok_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_SYNC_CHK && sync_hit) |=> ##1 tmr_run);

    p_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cfg_stb, row_latch, tmr_run}));

endmodule

// File: tb/stim_frame_ctrl_test.sv
module stim_frame_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sdi = 1'b0;
    logic        dreg_run, cfg_stb, tmr_run, row_latch, scan_run, row_clk;
    logic [2:0]  row_num;
    logic [17:0] cfg_word;
    logic [39:0] probe_lvl;

    stim_frame_ctrl uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .sdi       (sdi),
        .dreg_run  (dreg_run),
        .cfg_stb   (cfg_stb),
        .tmr_run   (tmr_run),
        .row_latch (row_latch),
        .scan_run  (scan_run),
        .row_clk   (row_clk),
        .row_num   (row_num),
        .cfg_word  (cfg_word),
        .probe_lvl (probe_lvl)
    );

    always #10 clk = ~clk;

    int          n_run = 0;
    int          n_fail = 0;
    bit          done = 1'b0;
    logic [15:0] hist = '0;
    int          pend_kind = 0;
    logic [39:0] pend_val = '0;
    int          excl_bad = 0;
    logic [17:0] cur_cfg = '0;
    bit          idle = 1'b1;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] probe_byte(input logic [39:0] w, input int k);
        return w[39-8*k -: 8];
    endfunction

    function automatic logic [39:0] probe_vec(input logic [39:0] w);
        logic [39:0] v;
        for (int k = 0; k < 5; k++) v[k*8 +: 8] = probe_byte(w, k);
        return v;
    endfunction

    function automatic logic [39:0] rnd40();
        logic [63:0] t;
        t = {$urandom(), $urandom()};
        return t[39:0];
    endfunction

    function automatic logic [5:0] outs();
        return {dreg_run, cfg_stb, tmr_run, row_latch, scan_run, row_clk};
    endfunction

    task automatic send_bit(input logic b);
        sdi  = b;
        hist = {hist[14:0], b};
        @(posedge clk);
        @(negedge clk);
        if (int'(cfg_stb) + int'(row_latch) + int'(tmr_run) > 1) excl_bad++;
        case (pend_kind)
            1: chk(cfg_word == pend_val[17:0], "R2 config captured", cfg_word, pend_val[17:0]);
            2: chk(probe_lvl == probe_vec(pend_val), "R5 R4 probe byte order after latch",
                   probe_lvl, probe_vec(pend_val));
            3: chk(scan_run && !tmr_run && dreg_run, "R8 restart cycle",
                   {scan_run, tmr_run, dreg_run}, 3'b101);
            4: chk(outs() == 6'b0, "R9 back to idle on bad sync", outs(), 0);
            default: ;
        endcase
        pend_kind = 0;
    endtask

    task automatic junk(input int n);
        int          bad = 0;
        logic [39:0] p0 = probe_lvl;
        logic [17:0] c0 = cfg_word;
        for (int i = 0; i < n; i++) begin
            logic b;
            b = 1'($urandom() % 2);
            if ({hist[14:0], b} == 16'hEEEE) b = ~b;
            send_bit(b);
            if (outs() != 6'b0) bad++;
            if (probe_lvl != p0 || cfg_word != c0) bad++;
        end
        chk(bad == 0, "R10 idle ignores non-start bits", bad, 0);
    endtask

    task automatic send_start();
        logic [15:0] tag = 16'hEEEE;
        repeat (8) send_bit(1'b1);
        for (int i = 15; i >= 0; i--) send_bit(tag[i]);
        chk(outs() == 6'b0, "R2 still idle on start tag", outs(), 0);
    endtask

    // kind 1: config, 2: row, 3: sync
    task automatic send_word(input logic [39:0] w, input int kind, input int exp_row);
        int bad = 0;
        for (int i = 39; i >= 0; i--) begin
            int idx;
            send_bit(w[i]);
            idx = 40 - i;
            if (idx >= 2 && idx <= 39) begin
                if (kind == 1)
                    bad += int'(dreg_run || cfg_stb || scan_run || tmr_run);
                else
                    bad += int'(!scan_run || !tmr_run || !dreg_run || row_latch || cfg_stb);
            end
        end
        if (kind == 1) begin
            chk(bad == 0, "R3 data register held clear during config", bad, 0);
            chk(cfg_stb && dreg_run && !row_latch && !scan_run, "R2 R3 config strobe after 40th bit",
                outs(), 6'b110000);
            pend_kind = 1;
            pend_val  = w;
        end else begin
            chk(bad == 0, "R6 timer and scan levels during word", bad, 0);
            if (kind == 2) begin
                chk(row_latch && row_clk && !tmr_run && scan_run && dreg_run &&
                    row_num == 3'(exp_row), "R4 R7 row strobes and number",
                    {outs(), row_num}, {6'b100111, 3'(exp_row)});
                pend_kind = 2;
                pend_val  = w;
            end else begin
                chk(!row_latch && !row_clk && scan_run && row_num == 3'd6,
                    "R7 sixth word not latched", {outs(), row_num}, {6'b100010, 3'd6});
                pend_kind = (w[15:0] == 16'hAAAA) ? 3 : 4;
            end
        end
    endtask

    function automatic logic [39:0] directed_row(input int r);
        case (r)
            1: return 40'h01_02_04_08_10;
            2: return 40'h20_40_80_FF_00;
            3: return 40'hB0_7F_00_01_FE;
            4: return 40'h00_00_00_00_00;
            default: return 40'hFF_FF_FF_FF_FF;
        endcase
    endfunction

    task automatic frame(input logic [17:0] cfg, input bit good, input bit random_rows);
        logic [39:0] sw;
        if (idle) begin
            send_start();
            send_word({22'($urandom()), cfg}, 1, 0);
            cur_cfg = cfg;
        end
        for (int r = 1; r <= 5; r++)
            send_word(random_rows ? rnd40() : directed_row(r), 2, r);
        sw = rnd40();
        if (good) sw[15:0] = 16'hAAAA;
        else if (sw[15:0] == 16'hAAAA) sw[15:0] = 16'h1234;
        send_word(sw, 3, 0);
        if (good) begin
            idle = 1'b0;
        end else begin
            idle = 1'b1;
            junk(20);
        end
        chk(cfg_word == cur_cfg, "R8 config kept across frames", cfg_word, cur_cfg);
    endtask

    initial begin
        void'($urandom(32'd7741));
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(outs() == 6'b0 && row_num == 0 && cfg_word == 0 && probe_lvl == 0,
            "R1 reset state", {outs(), row_num}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(outs() == 6'b0 && row_num == 0, "R1 idle after release", {outs(), row_num}, 0);

        junk(60);
        frame(18'h33DF3, 1'b1, 1'b0);
        frame(18'h00000, 1'b1, 1'b1);
        frame(18'h00000, 1'b0, 1'b1);
        junk(50);
        frame(18'h3BFFB, 1'b1, 1'b0);

        for (int f = 0; f < 8; f++)
            frame(18'($urandom()), ($urandom() % 4) != 0, 1'b1);

        // reset in the middle of a row word
        if (idle) begin
            send_start();
            send_word(40'h00_0003_FEFB, 1, 0);
        end
        for (int i = 0; i < 17; i++) send_bit(1'($urandom() % 2));
        rst_n = 1'b0;
        #2;
        chk(outs() == 6'b0 && row_num == 0 && cfg_word == 0 && probe_lvl == 0,
            "R1 reset mid-row clears all", {outs(), row_num}, 0);
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        hist = '0;
        idle = 1'b1;
        pend_kind = 0;
        @(negedge clk);
        junk(30);
        frame(18'h2AAAA, 1'b1, 1'b1);
        frame(18'h00000, 1'b0, 1'b1);

        chk(excl_bad == 0, "R11 exclusive strobes", excl_bad, 0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule